// File: doc/BRIEF.md
# Flash Controller Command and Interrupt Register Front End

This block is the register-facing front end of a NAND-style flash controller. Software reaches it through a simple read/write register bus. It holds six 16-bit registers: command, two configuration words, controller status, interrupt status and a start-buffer descriptor. When software writes an opcode, the block checks it. A recognised opcode becomes a one-cycle start pulse toward the operation engines, which also see the buffer index and sector count. Two opcodes reset the controller itself. Any other opcode is flagged as a command error straight away.

The operation engines report back on one done line and one error line per operation class: erase, program and load. Each completion sets the global pending flag together with that class's interrupt bit. When the error line is high, it also sets the command-error flag and the class's error flag. Software acknowledges by writing a mask that is ANDed into interrupt status. Clearing the pending flag this way also wipes every error flag. While the pending flag is set, command writes are dropped. The block drives a level interrupt whose polarity is chosen by a configuration bit, and a ready output controlled by software.

Top module: `flash_cmd_regs`

## Requirements
- R1: After power-on reset (rst_n low), reads return the following. Command (offset 0) reads 0x0000. Configuration 1 (offset 1) reads 0x40C0. Configuration 2 (offset 2) reads 0x0000. Status (offset 3) reads 0x0000. Interrupt status (offset 4) reads 0x8080. Start buffer (offset 5) reads 0x0001. The ready output is 1 and op_start is 0.
- R2: A read strobe returns data on reg_rdata with reg_rvalid high in the following cycle. Offsets 6 and above read 0.
- R3: A command write is dropped while interrupt status bit 15 is set. The command register keeps its value and no op_start pulse follows.
- R4: An accepted command write latches the value into the command register. If the value is one of 0x00, 0x13, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x80, 0x94, 0x95 or 0xB0, op_start is high for exactly the next cycle. In that cycle op_code carries the opcode, and op_buf and op_secs carry the start-buffer fields.
- R5: The start-buffer register stores bits 11:8 as the buffer index and bits 1:0 as the sector count. All other bits read 0. op_secs gives the count, with a stored 0 meaning 4.
- R6: A done pulse is visible from the next cycle. On op_done[0] (erase), interrupt bits 15 and 5 are set. On op_done[1] (program), bits 15 and 6 are set. On op_done[2] (load), bits 15 and 7 are set. If op_err of that class is high, status bit 10 is set together with bit 11 (erase), 12 (program) or 13 (load). No other status bits are ever set.
- R7: An accepted command write with an opcode outside the R4 list and the R8 pair has two effects from the next cycle: status bit 10 and interrupt bit 15 are set. No op_start pulse is given.
- R8: An accepted write of 0x00F0 or 0x00F3 performs a warm reset. The command register, configuration 2 and status become 0, configuration 1 becomes 0x40C0, interrupt status becomes 0x8010, the start buffer returns to 0x0001 and ready becomes 1.
- R9: A write to interrupt status replaces it with the old value ANDed with the written value. If bit 15 of the result is 0, status bits 13:10 are cleared.
- R10: The irq output equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6.
- R11: A configuration-1 write drives the ready output to bit 7 of the written value. Configuration 1 reads back masked with 0xFFE0.
- R12: A reset request pulse (rst_req) resets the registers as in R8. Interrupt status becomes 0x8080 when rst_cold is 1 and 0x8010 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset (cold values) |
| rst_req | input | 1 | Synchronous reset request pulse |
| rst_cold | input | 1 | With rst_req: 1 selects cold, 0 selects warm interrupt value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| op_start | output | 1 | One-cycle operation start pulse |
| op_code | output | 16 | Opcode of the started operation |
| op_buf | output | BUF_W | Buffer index for the operation |
| op_secs | output | CNT_W+1 | Sector count for the operation (1 to 4) |
| op_done | input | NUM_CLASS | Completion pulses: erase, program, load |
| op_err | input | NUM_CLASS | Error flags qualifying op_done |
| irq | output | 1 | Level interrupt, polarity set by configuration 1 bit 6 |
| ready | output | 1 | Ready level, set from configuration 1 bit 7 |

## Verification
Every register effect of a write, a done pulse or a reset request is in place one clock edge after the stimulus. op_start is high in exactly that next cycle, and read data arrives one cycle after its strobe. The bench drives stimulus on falling edges and samples the pulse-type outputs (op_start, irq, ready) on the next falling edge. Read results go into an expected-value queue, and a monitor compares each one against the queue head on the falling edge where reg_rvalid is high. A read is only issued after the edge that settles the state it inspects.

// File: rtl/flcr_pkg.sv
package flcr_pkg;
   localparam int REG_W = 16;

   // register offsets
   localparam int OFS_CMD   = 0;
   localparam int OFS_CFG1  = 1;
   localparam int OFS_CFG2  = 2;
   localparam int OFS_STAT  = 3;
   localparam int OFS_INT   = 4;
   localparam int OFS_SBUF  = 5;

   // status error flags
   localparam int ST_CMD_ERR = 10;
   localparam logic [REG_W-1:0] ST_ERR_MASK = 16'h3C00;

   // interrupt status
   localparam int IS_PEND = 15;

   localparam logic [REG_W-1:0] CFG1_RST     = 16'h40C0;
   localparam logic [REG_W-1:0] CFG1_RD_MASK = 16'hFFE0;
   localparam logic [REG_W-1:0] INT_COLD     = 16'h8080;
   localparam logic [REG_W-1:0] INT_WARM     = 16'h8010;
   localparam int CFG1_POL_BIT = 6;
   localparam int CFG1_RDY_BIT = 7;

   // class index -> interrupt bit (erase 5, program 6, load 7)
   function automatic int cls_int_bit(input int cls);
      return 5 + cls;
   endfunction

   // class index -> status error bit (erase 11, program 12, load 13)
   function automatic int cls_err_bit(input int cls);
      return 11 + cls;
   endfunction

   function automatic logic is_reset_op(input logic [REG_W-1:0] op);
      return (op == 16'h00F0) || (op == 16'h00F3);
   endfunction

   function automatic logic is_known_op(input logic [REG_W-1:0] op);
      case (op)
         16'h0000, 16'h0013, 16'h001A, 16'h001B,
         16'h0023, 16'h0027, 16'h002A, 16'h002C,
         16'h0030, 16'h0065, 16'h0071, 16'h0080,
         16'h0094, 16'h0095, 16'h00B0: return 1'b1;
         default:                      return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/flcr_cmd_decode.sv
module flcr_cmd_decode
   import flcr_pkg::*;
(
   input  logic             cmd_wr,
   input  logic             pend,
   input  logic [REG_W-1:0] cmd_val,
   output logic             go_start,
   output logic             go_reset,
   output logic             go_bad
);
   logic accept;

   always_comb begin
      accept   = cmd_wr & ~pend;
      go_reset = accept & is_reset_op(cmd_val);
      go_start = accept & is_known_op(cmd_val);
      go_bad   = accept & ~is_reset_op(cmd_val) & ~is_known_op(cmd_val);
   end
endmodule

// File: rtl/flcr_irq_out.sv
module flcr_irq_out #(
   parameter bit IRQ_FLOP = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend,
   input  logic pol,
   output logic irq
);
   logic irq_raw;

   assign irq_raw = pend ^ ~pol;

   generate
      if (IRQ_FLOP) begin : g_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b1;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/flcr_rd_mux.sv
module flcr_rd_mux
   import flcr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int BUF_W  = 4,
   parameter int CNT_W  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  cmd,
   input  logic [REG_W-1:0]  cfg1,
   input  logic [REG_W-1:0]  cfg2,
   input  logic [REG_W-1:0]  stat,
   input  logic [REG_W-1:0]  ints,
   input  logic [BUF_W-1:0]  sbuf_idx,
   input  logic [CNT_W-1:0]  sbuf_cnt,
   output logic [REG_W-1:0]  data
);
   logic [REG_W-1:0] sbuf_word;

   always_comb begin
      sbuf_word = '0;
      sbuf_word[8 +: BUF_W] = sbuf_idx;
      sbuf_word[0 +: CNT_W] = sbuf_cnt;
   end

   always_comb begin
      if      (addr == ADDR_W'(OFS_CMD))  data = cmd;
      else if (addr == ADDR_W'(OFS_CFG1)) data = cfg1 & CFG1_RD_MASK;
      else if (addr == ADDR_W'(OFS_CFG2)) data = cfg2;
      else if (addr == ADDR_W'(OFS_STAT)) data = stat;
      else if (addr == ADDR_W'(OFS_INT))  data = ints;
      else if (addr == ADDR_W'(OFS_SBUF)) data = sbuf_word;
      else                                data = '0;
   end
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
   import flcr_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int BUF_W     = 4,
   parameter int CNT_W     = 2,
   parameter int NUM_CLASS = 3,
   parameter bit IRQ_FLOP  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rst_req,
   input  logic                 rst_cold,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   output logic                 reg_rvalid,
   output logic                 op_start,
   output logic [REG_W-1:0]     op_code,
   output logic [BUF_W-1:0]     op_buf,
   output logic [CNT_W:0]       op_secs,
   input  logic [NUM_CLASS-1:0] op_done,
   input  logic [NUM_CLASS-1:0] op_err,
   output logic                 irq,
   output logic                 ready
);
   localparam int SEC_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 3)       begin : g_bad_addr  $error("ADDR_W must be at least 3"); end
      if (BUF_W < 1 || BUF_W > 4) begin : g_bad_buf $error("BUF_W must be 1..4"); end
      if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt $error("CNT_W must be 1..8"); end
      if (NUM_CLASS != 3)   begin : g_bad_cls   $error("NUM_CLASS must be 3"); end
   endgenerate

   logic [REG_W-1:0] cmd_q, cfg1_q, cfg2_q, status_q, int_q;
   logic [REG_W-1:0] cmd_n, cfg1_n, cfg2_n, status_n, int_n;
   logic [BUF_W-1:0] sidx_q, sidx_n;
   logic [CNT_W-1:0] scnt_q, scnt_n;
   logic             ready_q, ready_n;
   logic             start_q, start_n;
   logic [REG_W-1:0] rd_word, rdata_q;
   logic             rvalid_q;

   logic wr_cmd, wr_cfg1, wr_cfg2, wr_int, wr_sbuf;
   logic go_start, go_reset, go_bad;

   always_comb begin
      wr_cmd  = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
      wr_cfg1 = reg_wr && (reg_addr == ADDR_W'(OFS_CFG1));
      wr_cfg2 = reg_wr && (reg_addr == ADDR_W'(OFS_CFG2));
      wr_int  = reg_wr && (reg_addr == ADDR_W'(OFS_INT));
      wr_sbuf = reg_wr && (reg_addr == ADDR_W'(OFS_SBUF));
   end

   flcr_cmd_decode u_dec (
      .cmd_wr   (wr_cmd),
      .pend     (int_q[IS_PEND]),
      .cmd_val  (reg_wdata),
      .go_start (go_start),
      .go_reset (go_reset),
      .go_bad   (go_bad)
   );

   // next-state logic; later assignments take priority
   always_comb begin
      cmd_n    = cmd_q;
      cfg1_n   = cfg1_q;
      cfg2_n   = cfg2_q;
      sidx_n   = sidx_q;
      scnt_n   = scnt_q;
      ready_n  = ready_q;
      start_n  = 1'b0;

      if (wr_cfg1) begin
         cfg1_n  = reg_wdata;
         ready_n = reg_wdata[CFG1_RDY_BIT];
      end
      if (wr_cfg2) cfg2_n = reg_wdata;
      if (wr_sbuf) begin
         sidx_n = reg_wdata[8 +: BUF_W];
         scnt_n = reg_wdata[0 +: CNT_W];
      end

      // acknowledge: AND mask, clear errors once pending drops
      int_n    = wr_int ? (int_q & reg_wdata) : int_q;
      status_n = status_q;
      if (wr_int && !int_n[IS_PEND]) status_n = status_q & ~ST_ERR_MASK;

      // completions from the operation engines
      for (int c = 0; c < NUM_CLASS; c++) begin
         if (op_done[c]) begin
            int_n[IS_PEND]        = 1'b1;
            int_n[cls_int_bit(c)] = 1'b1;
            if (op_err[c]) begin
               status_n[ST_CMD_ERR]     = 1'b1;
               status_n[cls_err_bit(c)] = 1'b1;
            end
         end
      end

      if (go_start) begin
         cmd_n   = reg_wdata;
         start_n = 1'b1;
      end
      if (go_bad) begin
         cmd_n                = reg_wdata;
         status_n[ST_CMD_ERR] = 1'b1;
         int_n[IS_PEND]       = 1'b1;
      end

      if (go_reset || rst_req) begin
         cmd_n    = '0;
         cfg1_n   = CFG1_RST;
         cfg2_n   = '0;
         status_n = '0;
         sidx_n   = '0;
         scnt_n   = CNT_RST;
         ready_n  = 1'b1;
         start_n  = 1'b0;
         int_n    = (rst_req && rst_cold) ? INT_COLD : INT_WARM;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         cfg1_q   <= CFG1_RST;
         cfg2_q   <= '0;
         status_q <= '0;
         int_q    <= INT_COLD;
         sidx_q   <= '0;
         scnt_q   <= CNT_RST;
         ready_q  <= 1'b1;
         start_q  <= 1'b0;
      end else begin
         cmd_q    <= cmd_n;
         cfg1_q   <= cfg1_n;
         cfg2_q   <= cfg2_n;
         status_q <= status_n;
         int_q    <= int_n;
         sidx_q   <= sidx_n;
         scnt_q   <= scnt_n;
         ready_q  <= ready_n;
         start_q  <= start_n;
      end
   end

   flcr_rd_mux #(
      .ADDR_W (ADDR_W),
      .BUF_W  (BUF_W),
      .CNT_W  (CNT_W)
   ) u_rd (
      .addr     (reg_addr),
      .cmd      (cmd_q),
      .cfg1     (cfg1_q),
      .cfg2     (cfg2_q),
      .stat     (status_q),
      .ints     (int_q),
      .sbuf_idx (sidx_q),
      .sbuf_cnt (scnt_q),
      .data     (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= reg_rd;
         if (reg_rd) rdata_q <= rd_word;
      end
   end

   flcr_irq_out #(.IRQ_FLOP(IRQ_FLOP)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (int_q[IS_PEND]),
      .pol   (cfg1_q[CFG1_POL_BIT]),
      .irq   (irq)
   );

   assign reg_rdata  = rdata_q;
   assign reg_rvalid = rvalid_q;
   assign op_start   = start_q;
   assign op_code    = cmd_q;
   assign op_buf     = sidx_q;
   assign op_secs    = (scnt_q == '0) ? SEC_W'(1 << CNT_W) : SEC_W'(scnt_q);
   assign ready      = ready_q;
endmodule

// File: rtl/flcr_chk.sv
module flcr_chk
   import flcr_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int NUM_CLASS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rst_req,
   input logic                 rst_cold,
   input logic                 reg_wr,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic [REG_W-1:0]     reg_wdata,
   input logic                 op_start,
   input logic [NUM_CLASS-1:0] op_done,
   input logic [REG_W-1:0]     int_q,
   input logic [REG_W-1:0]     status_q
);
   logic cmd_wr, int_wr;
   assign cmd_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
   assign int_wr = reg_wr && (reg_addr == ADDR_W'(OFS_INT));

   p_cmd_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && int_q[IS_PEND]) |=> !op_start);

   p_start_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> $past(cmd_wr && !int_q[IS_PEND] && is_known_op(reg_wdata)));

   p_done_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|op_done) && !rst_req) |=> int_q[IS_PEND]);

   p_status_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~ST_ERR_MASK) == '0);

   p_bad_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !int_q[IS_PEND] && !is_known_op(reg_wdata) &&
       !is_reset_op(reg_wdata) && !rst_req) |=> (status_q[ST_CMD_ERR] && int_q[IS_PEND]));

   p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int_wr && !reg_wdata[IS_PEND] && !(|op_done) && !rst_req) |=> ((status_q & ST_ERR_MASK) == '0));

   p_req_warm_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !rst_cold) |=> (int_q == INT_WARM));
endmodule

bind flash_cmd_regs flcr_chk #(.ADDR_W(ADDR_W), .NUM_CLASS(NUM_CLASS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rst_req   (rst_req),
   .rst_cold  (rst_cold),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .op_start  (op_start),
   .op_done   (op_done),
   .int_q     (int_q),
   .status_q  (status_q)
);

// File: tb/tb_flash_cmd_regs.sv
module tb_flash_cmd_regs;
   logic        clk = 1'b0;
   logic        rst_n, rst_req, rst_cold;
   logic        reg_wr, reg_rd;
   logic [3:0]  reg_addr;
   logic [15:0] reg_wdata;
   logic [15:0] reg_rdata;
   logic        reg_rvalid;
   logic        op_start;
   logic [15:0] op_code;
   logic [3:0]  op_buf;
   logic [2:0]  op_secs;
   logic [2:0]  op_done, op_err;
   logic        irq, ready;

   always #5 clk = ~clk;

   flash_cmd_regs dut (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .rst_cold(rst_cold),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
      .op_start(op_start), .op_code(op_code), .op_buf(op_buf), .op_secs(op_secs),
      .op_done(op_done), .op_err(op_err), .irq(irq), .ready(ready)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares each returned read with the queue head
   always @(negedge clk) begin
      if (reg_rvalid) begin
         if (exp_q.size() == 0) begin
            chk("R2 unexpected read data", 32'(reg_rdata), 32'hFFFF_FFFF);
         end else begin
            automatic logic [15:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, 32'(reg_rdata), 32'(e));
         end
      end
   end

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
      reg_rd = 1'b1; reg_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic done(input int cls, input logic err);
      op_done[cls] = 1'b1; op_err[cls] = err;
      @(negedge clk);
      op_done = '0; op_err = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; rst_req = 1'b0; rst_cold = 1'b0;
      reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      op_done = '0; op_err = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ready", 32'(ready), 1);
      chk("R1 op_start", 32'(op_start), 0);
      chk("R10 irq after reset", 32'(irq), 1);
      rd(0, 16'h0000, "R1 command");
      rd(1, 16'h40C0, "R1 cfg1");
      rd(2, 16'h0000, "R1 cfg2");
      rd(3, 16'h0000, "R1 status");
      rd(4, 16'h8080, "R1 int cold");
      rd(5, 16'h0001, "R1 start buffer");
      rd(9, 16'h0000, "R2 unmapped");
      rd(15, 16'h0000, "R2 unmapped top");

      // R3 command dropped while pending
      wr(0, 16'h0094);
      chk("R3 no start while pending", 32'(op_start), 0);
      rd(0, 16'h0000, "R3 command unchanged");

      // acknowledge everything
      wr(4, 16'h0000);
      chk("R10 irq after clear", 32'(irq), 0);
      rd(4, 16'h0000, "R9 int cleared");

      // R5 start buffer fields
      wr(5, 16'hFFFF);
      rd(5, 16'h0F03, "R5 only fields kept");
      wr(5, 16'h0A02);
      rd(5, 16'h0A02, "R5 start buffer");

      // R4 accepted known command
      wr(0, 16'h0094);
      chk("R4 start pulse", 32'(op_start), 1);
      chk("R4 op_code", 32'(op_code), 32'h94);
      chk("R4 op_buf", 32'(op_buf), 32'hA);
      chk("R5 op_secs 2", 32'(op_secs), 2);
      @(negedge clk);
      chk("R4 single pulse", 32'(op_start), 0);
      rd(0, 16'h0094, "R4 command latched");

      wr(5, 16'h0300);
      wr(0, 16'h0000);
      chk("R4 start load", 32'(op_start), 1);
      chk("R5 op_secs zero means 4", 32'(op_secs), 4);
      chk("R4 op_buf 3", 32'(op_buf), 3);

      // R6 erase done with error
      done(0, 1'b1);
      chk("R10 irq on pending", 32'(irq), 1);
      rd(4, 16'h8020, "R6 erase int");
      rd(3, 16'h0C00, "R6 erase error");

      // R9 AND keeping pending: errors stay
      wr(4, 16'h80FF);
      rd(4, 16'h8020, "R9 and keeps pending");
      rd(3, 16'h0C00, "R9 errors held");
      wr(4, 16'h0020);
      rd(4, 16'h0020, "R9 and result");
      rd(3, 16'h0000, "R9 errors cleared");
      wr(4, 16'h0000);

      // R6 program ok, load with error
      done(1, 1'b0);
      rd(4, 16'h8040, "R6 program int");
      rd(3, 16'h0000, "R6 no error");
      wr(4, 16'h0000);
      done(2, 1'b1);
      rd(4, 16'h8080, "R6 load int");
      rd(3, 16'h2400, "R6 load error");
      wr(4, 16'h0000);
      rd(3, 16'h0000, "R9 load error cleared");

      // R7 unknown opcode
      wr(0, 16'h0055);
      chk("R7 no start", 32'(op_start), 0);
      rd(3, 16'h0400, "R7 cmd error");
      rd(4, 16'h8000, "R7 pending");
      rd(0, 16'h0055, "R7 command latched");
      wr(4, 16'h0000);

      // R10 / R11 polarity and ready
      wr(1, 16'h0000);
      chk("R11 ready low", 32'(ready), 0);
      chk("R10 irq inverted idle", 32'(irq), 1);
      wr(1, 16'h00FF);
      chk("R11 ready high", 32'(ready), 1);
      chk("R10 irq normal idle", 32'(irq), 0);
      rd(1, 16'h00E0, "R11 cfg1 masked");
      done(1, 1'b0);
      chk("R10 irq normal pending", 32'(irq), 1);
      wr(1, 16'h0080);
      chk("R10 irq inverted pending", 32'(irq), 0);
      wr(4, 16'h0000);

      // R8 warm reset opcodes
      wr(2, 16'h1234);
      wr(0, 16'h00F3);
      chk("R8 no start", 32'(op_start), 0);
      rd(4, 16'h8010, "R8 F3 int warm");
      rd(1, 16'h40C0, "R8 cfg1");
      rd(2, 16'h0000, "R8 cfg2");
      rd(0, 16'h0000, "R8 command");
      rd(5, 16'h0001, "R8 start buffer");
      chk("R8 ready", 32'(ready), 1);
      wr(4, 16'h0000);
      wr(0, 16'h00F0);
      rd(4, 16'h8010, "R8 F0 int warm");

      // R12 reset request
      wr(4, 16'h0000);
      wr(2, 16'h00AA);
      rst_req = 1'b1; rst_cold = 1'b1;
      @(negedge clk);
      rst_req = 1'b0; rst_cold = 1'b0;
      rd(4, 16'h8080, "R12 cold request");
      rd(2, 16'h0000, "R12 cfg2 cleared");
      wr(4, 16'h0000);
      rst_req = 1'b1;
      @(negedge clk);
      rst_req = 1'b0;
      rd(4, 16'h8010, "R12 warm request");

      repeat (3) @(negedge clk);
      chk("R2 scoreboard drained", 32'(exp_q.size()), 0);
      finish_run();
   end
endmodule